// File: doc/BRIEF.md
# Link Power Management Handshake Controller

This block sequences device-side power management for one function of a serial interconnect endpoint. It keeps the function's power state (only the full-power state D0 and the powered-down state D3 exist), which software changes through a single register write port. It also runs a small link-state machine that reports whether the link sits in the L1 or L0s low-power states, or has moved to the L2/L3-ready state.

Application logic drives single-cycle requests: a wake pulse, an equivalent out-of-band power-up pulse, and a turn-off pulse. When the link partner's Turn_Off message arrives, the block answers with Enter_L23, but only once the application raises a level-sensitive ready input. A pending-transfer input keeps the link out of L1 and pulls it back out of L1. All outgoing message requests go to the transmit path as one-cycle strobes carrying a type code, and they are paced by a transmit-ready input.

Top module: `lpm_handshake`

## Requirements
- R1: The power-state output holds only 3'b000 (D0) or 3'b011 (D3). A write with data 3'b000 or 3'b011 takes effect on the next cycle. A write with any other value (including 3'b001 and 3'b010) leaves the state unchanged.
- R2: A wake pulse sampled while the state is D3 sets the state to D0 on the next cycle and produces exactly one PME message strobe. A wake pulse sampled in D0 has no effect.
- R3: The out-of-band power-up pulse behaves exactly like the wake pulse: in D3 it returns the state to D0 with one PME strobe, and in D0 it does nothing.
- R4: After a received Turn_Off pulse, no Enter_L23 strobe is issued while the ready-for-L2/L3 input is low. Once that level is sampled high, one Enter_L23 strobe follows, and the L2/L3 flag rises in the same cycle as that strobe.
- R5: An application turn-off pulse produces exactly one Turn_Off message strobe. There is no acknowledge output.
- R6: A turn-off pulse that arrives while a Turn_Off request is still waiting for transmission is dropped. It also sets a sticky error output, which only reset clears.
- R7: The link enters L1 only when the state is D3 or the L1-request input is high, and the pending-transfer input was low at both the current and the previous clock edge.
- R8: When the pending-transfer input is sampled high while in L1, the L1 flag is low on the next cycle.
- R9: With the link-idle input high in L0, the L0s flag is set on the next cycle. It clears one cycle after idle drops. The L0s flag and the L1 flag are never high together.
- R10: A strobe appears on msg_valid one cycle after an edge at which transmit-ready was high with a request pending. The type codes are PME=1, Turn_Off=2 and Enter_L23=3, and msg_type is 0 when there is no strobe. Pending requests are served in the priority order PME, then Turn_Off, then Enter_L23.
- R11: After reset the state is D0, the link is in L0 with all link flags low, no strobe is issued, and the error output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ds_we | input | 1 | Power-state register write enable |
| cfg_ds_wdata | input | 3 | Power-state write data |
| app_wake | input | 1 | Single-cycle wake request |
| oob_pwrup | input | 1 | Single-cycle out-of-band power-up request |
| app_turnoff | input | 1 | Single-cycle request to send Turn_Off |
| rx_turnoff | input | 1 | Single-cycle indication that Turn_Off was received |
| app_l23_ready | input | 1 | Level: application is ready for L2/L3 |
| app_xfer_pending | input | 1 | Level: a transfer is pending |
| app_l1_req | input | 1 | Level: application allows L1 |
| link_idle | input | 1 | Level: link is idle (L0s candidate) |
| tx_ready | input | 1 | Transmit path can take a message |
| msg_valid | output | 1 | One-cycle message strobe |
| msg_type | output | 2 | Message type code |
| dstate | output | 3 | Current power state |
| link_in_l1 | output | 1 | Link is in L1 |
| link_in_l0s | output | 1 | Link is in L0s |
| link_in_l23 | output | 1 | Link is in L2/L3-ready |
| turnoff_overrun | output | 1 | Sticky flag: a turn-off pulse was dropped |

## Verification
The wake function is tried from D3 and from D0 through both wake inputs. This separates a correct state gate from a design that fires PME on every pulse. Turn-off is tried with transmit-ready high and with it held low while a second pulse and a wake arrive. That pattern separates single-issue behaviour, overrun detection and PME-first ordering. The L1 patterns raise and drop pending-transfer around L1 to expose whether the one-cycle low window is honoured. The L2/L3 sequence holds ready low for several cycles before raising it, which shows whether the response waits on the level.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  parameter int DS_W    = 3;
  parameter int MSG_W   = 2;
  parameter int NUM_MSG = 3;

  typedef logic [DS_W-1:0]    dstate_t;
  typedef logic [NUM_MSG-1:0] msgvec_t;

  localparam dstate_t DS_D0 = 3'b000;
  localparam dstate_t DS_D3 = 3'b011;

  // request index: lower index wins arbitration
  localparam int IDX_PME  = 0;
  localparam int IDX_TOFF = 1;
  localparam int IDX_L23  = 2;

  typedef enum logic [MSG_W-1:0] {
    MSG_NONE = 2'd0,
    MSG_PME  = 2'd1,
    MSG_TOFF = 2'd2,
    MSG_L23  = 2'd3
  } msg_t;

  typedef enum logic [1:0] {
    LK_L0  = 2'd0,
    LK_L0S = 2'd1,
    LK_L1  = 2'd2,
    LK_L23 = 2'd3
  } link_t;

  function automatic logic ds_legal(input dstate_t d);
    return (d == DS_D0) || (d == DS_D3);
  endfunction

  function automatic logic ds_is_low(input dstate_t d);
    return d == DS_D3;
  endfunction

  function automatic logic l1_allowed(input logic in_d3, input logic l1_req,
                                      input logic xp_now, input logic xp_prev);
    return (in_d3 || l1_req) && !xp_now && !xp_prev;
  endfunction

  // isolate lowest set bit
  function automatic msgvec_t first_set(input msgvec_t v);
    return v & (~v + msgvec_t'(1));
  endfunction

  function automatic msg_t onehot_code(input msgvec_t oh);
    msg_t c;
    c = MSG_NONE;
    for (int i = 0; i < NUM_MSG; i++)
      if (oh[i]) c = msg_t'(i + 1);
    return c;
  endfunction

endpackage

// File: rtl/lpm_dstate.sv
module lpm_dstate
  import lpm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  dstate_t wr_data,
  input  logic    wake,
  input  logic    oob_pwrup,
  output dstate_t dstate,
  output logic    wake_evt
);

  dstate_t ds_q;
  dstate_t ds_d;
  logic    wr_ok;

  assign wake_evt = (wake || oob_pwrup) && ds_is_low(ds_q);
  assign wr_ok    = wr_en && ds_legal(wr_data);

  always_comb begin
    ds_d = ds_q;
    if (wake_evt)   ds_d = DS_D0;
    else if (wr_ok) ds_d = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ds_q <= DS_D0;
    else        ds_q <= ds_d;
  end

  assign dstate = ds_q;

endmodule

// File: rtl/lpm_msg_arb.sv
module lpm_msg_arb
  import lpm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  msgvec_t set_vec,
  input  logic    tx_ready,
  output msgvec_t pend_vec,
  output msgvec_t gnt_vec,
  output logic    msg_valid,
  output msg_t    msg_type
);

  msgvec_t pend_q;
  logic    valid_q;
  msg_t    type_q;

  assign gnt_vec = tx_ready ? first_set(pend_q) : '0;

  for (genvar i = 0; i < NUM_MSG; i++) begin : g_pend
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= set_vec[i] | (pend_q[i] & ~gnt_vec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      type_q  <= MSG_NONE;
    end else begin
      valid_q <= |gnt_vec;
      type_q  <= onehot_code(gnt_vec);
    end
  end

  assign pend_vec  = pend_q;
  assign msg_valid = valid_q;
  assign msg_type  = type_q;

endmodule

// File: rtl/lpm_link_fsm.sv
module lpm_link_fsm
  import lpm_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  dstate_t dstate,
  input  logic    l1_req,
  input  logic    xfer_pending,
  input  logic    link_idle,
  input  logic    wake_evt,
  input  logic    l23_gnt,
  output logic    in_l1,
  output logic    in_l0s,
  output logic    in_l23,
  output logic    l1_ok
);

  link_t st_q;
  link_t st_d;
  logic  xp_q;

  assign l1_ok = l1_allowed(ds_is_low(dstate), l1_req, xfer_pending, xp_q);

  always_comb begin
    st_d = st_q;
    if (l23_gnt)       st_d = LK_L23;
    else if (wake_evt) st_d = LK_L0;
    else begin
      case (st_q)
        LK_L0:   if (l1_ok) st_d = LK_L1;
                 else if (link_idle) st_d = LK_L0S;
        LK_L0S:  if (l1_ok) st_d = LK_L1;
                 else if (!link_idle) st_d = LK_L0;
        LK_L1:   if (xfer_pending) st_d = LK_L0;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= LK_L0;
      xp_q <= 1'b0;
    end else begin
      st_q <= st_d;
      xp_q <= xfer_pending;
    end
  end

  assign in_l1  = st_q == LK_L1;
  assign in_l0s = st_q == LK_L0S;
  assign in_l23 = st_q == LK_L23;

endmodule

// File: rtl/lpm_handshake.sv
module lpm_handshake
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_ds_we,
  input  logic [2:0] cfg_ds_wdata,
  input  logic       app_wake,
  input  logic       oob_pwrup,
  input  logic       app_turnoff,
  input  logic       rx_turnoff,
  input  logic       app_l23_ready,
  input  logic       app_xfer_pending,
  input  logic       app_l1_req,
  input  logic       link_idle,
  input  logic       tx_ready,
  output logic       msg_valid,
  output logic [1:0] msg_type,
  output logic [2:0] dstate,
  output logic       link_in_l1,
  output logic       link_in_l0s,
  output logic       link_in_l23,
  output logic       turnoff_overrun
);

  dstate_t ds;
  logic    wake_evt;
  msgvec_t set_vec, pend_vec, gnt_vec;
  msg_t    mtype;
  logic    l23_wait_q;
  logic    l23_set;
  logic    toff_drop;
  logic    err_q;
  logic    l23_gnt;
  logic    l1_ok;

  lpm_dstate u_ds (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_ds_we), .wr_data(cfg_ds_wdata),
    .wake(app_wake), .oob_pwrup(oob_pwrup),
    .dstate(ds), .wake_evt(wake_evt)
  );

  // named events for the checker
  assign toff_drop = app_turnoff && pend_vec[IDX_TOFF];
  assign l23_set   = l23_wait_q && app_l23_ready;
  assign l23_gnt   = gnt_vec[IDX_L23];

  always_comb begin
    set_vec           = '0;
    set_vec[IDX_PME]  = wake_evt;
    set_vec[IDX_TOFF] = app_turnoff && !pend_vec[IDX_TOFF];
    set_vec[IDX_L23]  = l23_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l23_wait_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (rx_turnoff)   l23_wait_q <= 1'b1;
      else if (l23_set) l23_wait_q <= 1'b0;
      if (toff_drop) err_q <= 1'b1;
    end
  end

  lpm_msg_arb u_arb (
    .clk(clk), .rst_n(rst_n),
    .set_vec(set_vec), .tx_ready(tx_ready),
    .pend_vec(pend_vec), .gnt_vec(gnt_vec),
    .msg_valid(msg_valid), .msg_type(mtype)
  );

  lpm_link_fsm u_link (
    .clk(clk), .rst_n(rst_n),
    .dstate(ds), .l1_req(app_l1_req),
    .xfer_pending(app_xfer_pending), .link_idle(link_idle),
    .wake_evt(wake_evt), .l23_gnt(l23_gnt),
    .in_l1(link_in_l1), .in_l0s(link_in_l0s), .in_l23(link_in_l23),
    .l1_ok(l1_ok)
  );

  assign msg_type        = mtype;
  assign dstate          = ds;
  assign turnoff_overrun = err_q;

endmodule

// File: rtl/lpm_handshake_chk.sv
module lpm_handshake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       app_wake,
  input logic       oob_pwrup,
  input logic       app_xfer_pending,
  input logic       tx_ready,
  input logic       msg_valid,
  input logic [1:0] msg_type,
  input logic [2:0] dstate,
  input logic       link_in_l1,
  input logic       link_in_l0s,
  input logic       link_in_l23,
  input logic       turnoff_overrun,
  input logic       toff_drop
);

  AST_DSTATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (dstate == 3'b000) || (dstate == 3'b011)); // R1

  AST_WAKE_TO_D0: assert property (@(posedge clk) disable iff (!rst_n)
    ((app_wake || oob_pwrup) && dstate == 3'b011) |=> dstate == 3'b000); // R2 R3

  AST_L23_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_type == 2'd3) |-> link_in_l23); // R4

  AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    toff_drop |=> turnoff_overrun); // R6

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    turnoff_overrun |=> turnoff_overrun); // R6

  AST_L1_ENTRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_in_l1) |-> $past(!app_xfer_pending)); // R7

  AST_L1_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (link_in_l1 && app_xfer_pending) |=> !link_in_l1); // R8

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_in_l1 && link_in_l0s)); // R9

  AST_STROBE_PACED: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(tx_ready)); // R10

  AST_TYPE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> msg_type == 2'd0); // R10

endmodule

bind lpm_handshake lpm_handshake_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .app_wake(app_wake), .oob_pwrup(oob_pwrup),
  .app_xfer_pending(app_xfer_pending), .tx_ready(tx_ready),
  .msg_valid(msg_valid), .msg_type(msg_type), .dstate(dstate),
  .link_in_l1(link_in_l1), .link_in_l0s(link_in_l0s), .link_in_l23(link_in_l23),
  .turnoff_overrun(turnoff_overrun), .toff_drop(toff_drop)
);

// File: tb/lpm_handshake_test.sv
`timescale 1ns/1ps
module lpm_handshake_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_ds_we = 1'b0;
  logic [2:0] cfg_ds_wdata = 3'b000;
  logic       app_wake = 1'b0, oob_pwrup = 1'b0, app_turnoff = 1'b0, rx_turnoff = 1'b0;
  logic       app_l23_ready = 1'b0, app_xfer_pending = 1'b0, app_l1_req = 1'b0;
  logic       link_idle = 1'b0, tx_ready = 1'b1;
  logic       msg_valid;
  logic [1:0] msg_type;
  logic [2:0] dstate;
  logic       link_in_l1, link_in_l0s, link_in_l23, turnoff_overrun;

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] exp_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  lpm_handshake uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every strobe must match the next expected item
  always @(negedge clk) begin
    if (rst_n && msg_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected strobe", msg_type, 0);
      else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check(msg_type == e, "R10 message type/order", msg_type, e);
      end
    end
  end

  task automatic expect_msg(input logic [1:0] t);
    exp_q.push_back(t);
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ds_write(input logic [2:0] v);
    @(negedge clk); cfg_ds_we = 1'b1; cfg_ds_wdata = v;
    @(negedge clk); cfg_ds_we = 1'b0;
  endtask

  task automatic pulse_wake(input bit oob);
    @(negedge clk);
    if (oob) oob_pwrup = 1'b1; else app_wake = 1'b1;
    @(negedge clk); oob_pwrup = 1'b0; app_wake = 1'b0;
  endtask

  task automatic pulse_toff();
    @(negedge clk); app_turnoff = 1'b1;
    @(negedge clk); app_turnoff = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    cyc(2);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      report();
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(dstate == 3'b000, "R11 dstate", dstate, 0);
    check(!link_in_l1 && !link_in_l0s && !link_in_l23, "R11 link flags",
          {link_in_l1, link_in_l0s, link_in_l23}, 0);
    check(!msg_valid && !turnoff_overrun, "R11 strobe/err", {msg_valid, turnoff_overrun}, 0);

    // R1 legal and illegal writes
    ds_write(3'b011);
    check(dstate == 3'b011, "R1 write D3", dstate, 3);
    ds_write(3'b001);
    check(dstate == 3'b011, "R1 D1 ignored", dstate, 3);
    ds_write(3'b010);
    check(dstate == 3'b011, "R1 D2 ignored", dstate, 3);

    // R2 wake from D3
    expect_msg(2'd1);
    pulse_wake(1'b0);
    check(dstate == 3'b000, "R2 wake to D0", dstate, 0);
    drain("R2 one PME");
    // R2 wake in D0: no strobe
    pulse_wake(1'b0);
    drain("R2 no effect in D0");
    check(dstate == 3'b000, "R2 stays D0", dstate, 0);

    // R3 out-of-band power-up
    ds_write(3'b011);
    expect_msg(2'd1);
    pulse_wake(1'b1);
    check(dstate == 3'b000, "R3 oob to D0", dstate, 0);
    drain("R3 one PME");
    pulse_wake(1'b1);
    drain("R3 no effect in D0");

    // R5 single turn-off
    expect_msg(2'd2);
    pulse_toff();
    drain("R5 one Turn_Off");
    check(!turnoff_overrun, "R5 no error", turnoff_overrun, 0);

    // R6 overrun and R10 priority
    tx_ready = 1'b0;
    pulse_toff();
    pulse_toff();
    check(turnoff_overrun, "R6 sticky set", turnoff_overrun, 1);
    ds_write(3'b011);
    pulse_wake(1'b0);
    cyc(3);
    check(exp_q.size() == 0, "R10 held while not ready", 0, 0);
    expect_msg(2'd1);
    expect_msg(2'd2);
    tx_ready = 1'b1;
    drain("R6 R10 PME then single Turn_Off");
    check(turnoff_overrun, "R6 sticky holds", turnoff_overrun, 1);

    // R7 L1 entry
    @(negedge clk); app_l1_req = 1'b1;
    cyc(2);
    check(link_in_l1, "R7 L1 entered", link_in_l1, 1);
    // R8 exit on pending
    app_xfer_pending = 1'b1;
    @(negedge clk);
    check(!link_in_l1, "R8 L1 exit", link_in_l1, 0);
    cyc(2);
    check(!link_in_l1, "R7 blocked while pending", link_in_l1, 0);
    app_xfer_pending = 1'b0;
    @(negedge clk);
    check(!link_in_l1, "R7 needs one full low cycle", link_in_l1, 0);
    @(negedge clk);
    check(link_in_l1, "R7 re-entry", link_in_l1, 1);
    app_xfer_pending = 1'b1;
    @(negedge clk);
    app_l1_req = 1'b0; app_xfer_pending = 1'b0;

    // R9 L0s
    link_idle = 1'b1;
    @(negedge clk);
    check(link_in_l0s && !link_in_l1, "R9 L0s entered", {link_in_l0s, link_in_l1}, 2);
    link_idle = 1'b0;
    @(negedge clk);
    check(!link_in_l0s, "R9 L0s left", link_in_l0s, 0);

    // R4 L2/L3 entry waits on ready level
    @(negedge clk); rx_turnoff = 1'b1;
    @(negedge clk); rx_turnoff = 1'b0;
    cyc(6);
    check(!link_in_l23 && exp_q.size() == 0, "R4 held while not ready", link_in_l23, 0);
    expect_msg(2'd3);
    app_l23_ready = 1'b1;
    cyc(2);
    check(link_in_l23, "R4 L23 flag with strobe", link_in_l23, 1);
    drain("R4 one Enter_L23");

    done = 1'b1;
    report();
  end

endmodule